// File: doc/BRIEF.md
# Programmable Third-Order Sinc Decimator

This block sits behind a fixed decimation chain and lowers the sample rate further by a programmable ratio D. A cascade of three integrators runs at the input rate. A cascade of three combs, each with a delay of one decimated sample, runs once every D accepted inputs. The result is the response (1 - z^-D)^3 / (1 - z^-1)^3. The datapath grows by three times the address width of the largest ratio, so no intermediate value can overflow.

D is not programmed directly. The user gives a requested output word rate and a family bit. The bit picks a base rate of 3840 (bit clear) or 3200 (bit set), and D is the integer quotient of the base divided by the requested rate. A small divider built into the block computes it every cycle. When the quotient is 1 or less, or when the bypass pin is high, the filter is skipped. In that case each input sample is sign-extended onto the output one cycle later. Any change to the rate, family or bypass inputs clears all filter state. The next three decimated results are then withheld while the cascade refills.

Top module: `sinc3_decim`

## Requirements
- R1: The ratio D is the truncated quotient of the base rate (3840 when `rate_fam` is 0, 3200 when it is 1) divided by `rate_owr`; for example 120 with family 0 gives D = 32, 60 gives 64, and 100 with family 1 gives 32.
- R2: When the quotient exceeds DMAX, or `rate_owr` is zero, D is held at DMAX (256 by default).
- R3: When `bypass` is high or the quotient is 1 or less, `out_valid` equals `in_valid` of the previous cycle, and each valid input appears on `out_data` sign-extended to the output width.
- R4: With the filter active, `out_valid` pulses for one cycle, in the cycle after every D-th accepted input, counting from the last reset or configuration change.
- R5: Each released result equals the input sequence since the last flush, zero before it, convolved with three cascaded length-D boxcars, as an OW-bit two's-complement value with OW = IW + 3·ceil(log2 DMAX).
- R6: A cycle in which `rate_owr`, `rate_fam` or `bypass` differs from its value in the previous cycle clears all integrator, comb and count state. The input offered in that cycle is dropped, and `out_valid` is low in the following cycle.
- R7: The first three decimated results after reset or a configuration change are not released: `out_valid` stays low for them.
- R8: `out_data` changes only in a cycle where `out_valid` is high.
- R9: During reset `out_valid` is 0 and `out_data` is 0.
- R10: Input cycles with `in_valid` low change neither the filter state nor the count, whatever `in_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_data | input | IW | Signed input sample from the fixed chain |
| in_valid | input | 1 | Input sample strobe |
| rate_owr | input | 12 | Requested output word rate in samples per second |
| rate_fam | input | 1 | Base-rate family: 0 selects 3840, 1 selects 3200 |
| bypass | input | 1 | Forces pass-through of the input |
| out_data | output | OW | Signed filtered sample, or sign-extended input in pass-through |
| out_valid | output | 1 | Output sample strobe |

## Verification
Two events can land in the same cycle: a configuration change and a valid input sample. The flush must win, so that sample is dropped. The bench provokes this by moving the rate and raising `in_valid` at the same clock edge, once from one active ratio to another and once from pass-through into filtering. The behavioural model in the bench discards that sample as well. The bench then counts released pulses in the phase and checks that the total is the number of full ratios of later inputs, less three, and that every released value matches the model.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int RATE_W = 12;
  localparam int ORDER  = 3;
endpackage

// File: rtl/sinc3_rate_div.sv
module sinc3_rate_div #(
  parameter int NW = 12,
  parameter int DW = 12
) (
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [NW-1:0] quo
);
  logic [NW-1:0][DW-1:0] rem;

  assign rem[0] = '0;

  for (genvar g = 0; g < NW; g++) begin : g_stage
    logic [DW:0] sh;
    logic        fits;
    assign sh   = {rem[g], num[NW-1-g]};
    assign fits = (sh >= {1'b0, den});
    assign quo[NW-1-g] = fits;
    if (g < NW-1) begin : g_carry
      assign rem[g+1] = fits ? (sh[DW-1:0] - den) : sh[DW-1:0];
    end
  end
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int W      = 48,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] x,
  output logic [W-1:0] y_nxt
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic [W-1:0] acc_q;
    logic [W-1:0] acc_n;
    logic [W-1:0] feed;
    logic [W-1:0] sum;

    if (g == 0) begin : g_head
      assign feed = x;
    end else begin : g_link
      assign feed = g_stg[g-1].sum;
    end

    assign sum = acc_q + feed;

    always_comb begin
      acc_n = acc_q;
      if (clr)     acc_n = '0;
      else if (en) acc_n = sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_n;
    end
  end

  assign y_nxt = g_stg[STAGES-1].sum;
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int W      = 48,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic [W-1:0] dly_q;
    logic [W-1:0] dly_n;
    logic [W-1:0] feed;
    logic [W-1:0] dif;

    if (g == 0) begin : g_head
      assign feed = x;
    end else begin : g_link
      assign feed = g_stg[g-1].dif;
    end

    assign dif = feed - dly_q;

    always_comb begin
      dly_n = dly_q;
      if (clr)     dly_n = '0;
      else if (en) dly_n = feed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly_q <= '0;
      else        dly_q <= dly_n;
    end
  end

  assign y = g_stg[STAGES-1].dif;
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
#(
  parameter  int IW    = 24,
  parameter  int DMAX  = 256,
  parameter  int BASE0 = 3840,
  parameter  int BASE1 = 3200,
  localparam int OW    = IW + ORDER * $clog2(DMAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     in_data,
  input  logic              in_valid,
  input  logic [RATE_W-1:0] rate_owr,
  input  logic              rate_fam,
  input  logic              bypass,
  output logic [OW-1:0]     out_data,
  output logic              out_valid
);
  localparam int BMAX = (BASE0 > BASE1) ? BASE0 : BASE1;
  localparam int NW   = $clog2(BMAX + 1);
  localparam int DW   = $clog2(DMAX + 1);
  localparam int WW   = $clog2(ORDER + 1);
  localparam int CW   = RATE_W + 2;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  // ratio derivation
  logic [NW-1:0] base_sel;
  logic [NW-1:0] quo;
  logic [DW-1:0] d_sel;
  logic [DW-1:0] d_last;
  logic          pass_sel;

  assign base_sel = rate_fam ? NW'(BASE1) : NW'(BASE0);

  sinc3_rate_div #(.NW(NW), .DW(RATE_W)) i_div (
    .num (base_sel),
    .den (rate_owr),
    .quo (quo)
  );

  assign d_sel    = (32'(quo) > 32'(DMAX)) ? DW'(DMAX) : DW'(quo);
  assign d_last   = d_sel - DW'(1);
  assign pass_sel = bypass | (quo <= NW'(1));

  // configuration tracking
  logic [CW-1:0] cfg_cur;
  logic [CW-1:0] cfg_q;
  logic          cfg_chg;

  assign cfg_cur = {rate_owr, rate_fam, bypass};
  assign cfg_chg = (cfg_cur != cfg_q);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) cfg_q <= '0;
    else          cfg_q <= cfg_cur;
  end

  // datapath
  logic          acc;
  logic          last;
  logic          dec;
  logic [OW-1:0] x_ext;
  logic [OW-1:0] i3_nxt;
  logic [OW-1:0] comb_y;

  assign x_ext = {{(OW-IW){in_data[IW-1]}}, in_data};
  assign acc   = in_valid & ~pass_sel & ~cfg_chg;

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_n;
  assign last = (cnt_q == d_last);
  assign dec  = acc & last;

  sinc3_integ #(.W(OW), .STAGES(ORDER)) i_integ (
    .clk   (clk),
    .rst_n (rst_q_n),
    .clr   (cfg_chg),
    .en    (acc),
    .x     (x_ext),
    .y_nxt (i3_nxt)
  );

  sinc3_comb #(.W(OW), .STAGES(ORDER)) i_comb (
    .clk   (clk),
    .rst_n (rst_q_n),
    .clr   (cfg_chg),
    .en    (dec),
    .x     (i3_nxt),
    .y     (comb_y)
  );

  // sequencing state
  logic [WW-1:0] warm_q;
  logic [WW-1:0] warm_n;
  logic          ov_q;
  logic          ov_n;
  logic [OW-1:0] od_q;
  logic [OW-1:0] od_n;
  logic          od_ld;

  always_comb begin
    cnt_n  = cnt_q;
    warm_n = warm_q;
    ov_n   = 1'b0;
    od_n   = od_q;
    od_ld  = 1'b0;
    if (cfg_chg) begin
      cnt_n  = '0;
      warm_n = WW'(ORDER);
    end else if (pass_sel) begin
      ov_n = in_valid;
      if (in_valid) begin
        od_n  = x_ext;
        od_ld = 1'b1;
      end
    end else if (acc) begin
      cnt_n = last ? '0 : cnt_q + DW'(1);
      if (last) begin
        if (warm_q != '0) begin
          warm_n = warm_q - WW'(1);
        end else begin
          ov_n  = 1'b1;
          od_n  = comb_y;
          od_ld = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cnt_q  <= '0;
      warm_q <= WW'(ORDER);
      ov_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      warm_q <= warm_n;
      ov_q   <= ov_n;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   od_q <= '0;
    else if (od_ld) od_q <= od_n;
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk
  import sinc3_pkg::*;
#(
  parameter int OW = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              bypass,
  input logic [RATE_W-1:0] rate_owr,
  input logic              rate_fam,
  input logic              out_valid,
  input logic [OW-1:0]     out_data
);
  // R4: a released sample always follows an offered input
  a_r4_valid_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R3: in steady pass-through the strobe is a one-cycle copy
  a_r3_bypass_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && $past(rst_n) && $stable(bypass) && $stable(rate_owr) && $stable(rate_fam))
      |=> (out_valid == $past(in_valid)));

  // R6: a configuration change silences the next cycle
  a_r6_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !($stable(bypass) && $stable(rate_owr) && $stable(rate_fam)))
      |=> !out_valid);

  // R8: output data moves only with the strobe
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

bind sinc3_decim sinc3_decim_chk #(.OW(OW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .in_valid  (in_valid),
  .bypass    (bypass),
  .rate_owr  (rate_owr),
  .rate_fam  (rate_fam),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/test_sinc3_decim.sv
module test_sinc3_decim;
  localparam int CLK_PERIOD = 10;
  localparam int IW   = 24;
  localparam int DMAX = 256;
  localparam int OW   = IW + 3 * $clog2(DMAX);

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [IW-1:0] in_data = '0;
  logic          in_valid = 1'b0;
  logic [11:0]   rate_owr = 12'd120;
  logic          rate_fam = 1'b0;
  logic          bypass = 1'b0;
  logic [OW-1:0] out_data;
  logic          out_valid;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    pulses  = 0;
  bit    chk_on  = 1'b0;
  bit    done    = 1'b0;
  string cur_req = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  sinc3_decim #(.IW(IW), .DMAX(DMAX)) i_sinc3_decim (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .rate_owr  (rate_owr),
    .rate_fam  (rate_fam),
    .bypass    (bypass),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R1/R2: truncated quotient of the selected base, huge for a zero rate
  function automatic int calc_q(input int owr, input bit fam);
    int base;
    base = fam ? 3200 : 3840;
    if (owr == 0) return 1 << 30;
    return base / owr;
  endfunction

  // behavioural reference
  logic [OW-1:0] exp_d;
  logic          exp_v;
  longint        hist[$];
  longint        h[];
  int            m_cnt, m_warm, m_d;
  logic [13:0]   prev_cfg;

  function automatic void build_h(input int d);
    longint t2[];
    t2 = new[2*d-1];
    foreach (t2[i]) t2[i] = 0;
    for (int i = 0; i < d; i++)
      for (int k = 0; k < d; k++) t2[i+k] += 1;
    h = new[3*d-2];
    foreach (h[i]) h[i] = 0;
    for (int i = 0; i < 2*d-1; i++)
      for (int k = 0; k < d; k++) h[i+k] += t2[i];
  endfunction

  always @(posedge clk) begin
    logic [13:0] cfg;
    int q, d, n;
    bit pass;
    longint y;
    cfg = {rate_owr, rate_fam, bypass};
    if (!rst_n) begin
      exp_v = 1'b0; exp_d = '0; m_cnt = 0; m_warm = 3; m_d = 0;
      hist.delete(); prev_cfg = cfg;
    end else begin
      q = calc_q(int'(rate_owr), rate_fam);
      d = (q > DMAX) ? DMAX : q;
      pass = bypass || (q <= 1);
      if (cfg != prev_cfg) begin
        hist.delete(); m_cnt = 0; m_warm = 3; exp_v = 1'b0;
      end else if (pass) begin
        exp_v = in_valid;
        if (in_valid) exp_d = OW'(longint'($signed(in_data)));
      end else begin
        exp_v = 1'b0;
        if (in_valid) begin
          if (d != m_d) begin build_h(d); m_d = d; end
          hist.push_back(longint'($signed(in_data)));
          if (hist.size() > 3*d) void'(hist.pop_front());
          m_cnt++;
          if (m_cnt == d) begin
            m_cnt = 0;
            n = hist.size();
            y = 0;
            for (int j = 0; j < 3*d-2 && j < n; j++) y += h[j] * hist[n-1-j];
            if (m_warm > 0) m_warm--;
            else begin exp_v = 1'b1; exp_d = OW'(y); end
          end
        end
      end
      prev_cfg = cfg;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      check(out_valid === exp_v, cur_req, "out_valid", longint'(out_valid), longint'(exp_v));
      check(out_data === exp_d, exp_v ? cur_req : "R8", "out_data",
            longint'(out_data), longint'(exp_d));
      if (out_valid) pulses++;
    end
  end

  function automatic logic [IW-1:0] gen(input int mode);
    if (mode == 1) return {1'b0, {(IW-1){1'b1}}};
    if (mode == 2) return {1'b1, {(IW-1){1'b0}}};
    return IW'($urandom);
  endfunction

  task automatic run_phase(input int owr, input bit fam, input bit byp, input int nin,
                           input int dens, input int dmode, input bit chg_with_data,
                           input string req);
    int sent, q, d, expn;
    cur_req = req;
    if (!chg_with_data) begin
      rate_owr = 12'(owr); rate_fam = fam; bypass = byp; in_valid = 1'b0;
      repeat (4) @(negedge clk);
      pulses = 0;
    end else begin
      pulses = 0;
      rate_owr = 12'(owr); rate_fam = fam; bypass = byp;
      in_valid = 1'b1; in_data = gen(dmode);   // R6: dropped by the flush
      @(negedge clk);
    end
    sent = 0;
    while (sent < nin) begin
      if ($urandom_range(99) < dens) begin
        in_valid = 1'b1; in_data = gen(dmode); sent++;
      end else begin
        in_valid = 1'b0; in_data = IW'($urandom);   // R10: ignored
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    q = calc_q(owr, fam);
    d = (q > DMAX) ? DMAX : q;
    if (byp || q <= 1) expn = nin;
    else expn = (nin / d > 3) ? nin / d - 3 : 0;
    check(pulses == expn, req, "pulse count (R4/R7)", longint'(pulses), longint'(expn));
  endtask

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R9", "reset out_valid", longint'(out_valid), 0);
    check(out_data === '0, "R9", "reset out_data", longint'(out_data), 0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    repeat (6) @(negedge clk);

    run_phase(120,  0, 0, 8*32,  100, 0, 0, "R1");   // D = 32
    run_phase(60,   0, 0, 6*64,  50,  0, 0, "R10");  // D = 64, sparse
    run_phase(100,  1, 0, 6*32,  80,  0, 0, "R1");   // family 1, D = 32
    run_phase(3840, 0, 0, 40,    70,  0, 0, "R3");
    run_phase(3200, 1, 0, 40,    70,  0, 0, "R3");
    run_phase(4000, 0, 0, 30,    60,  0, 0, "R3");   // quotient 0
    run_phase(60,   0, 1, 30,    60,  0, 0, "R3");   // bypass pin
    run_phase(15,   0, 0, 5*256, 100, 1, 0, "R5");   // D = 256, full positive
    run_phase(16,   0, 0, 5*240, 100, 2, 0, "R5");   // D = 240, full negative
    run_phase(1,    0, 0, 4*256, 100, 0, 0, "R2");   // clamp
    run_phase(0,    1, 0, 4*256, 100, 0, 0, "R2");   // zero rate
    run_phase(1920, 0, 0, 20,    60,  0, 0, "R4");   // D = 2
    run_phase(1280, 0, 0, 9,     100, 0, 0, "R7");   // D = 3, all suppressed
    run_phase(1067, 1, 0, 30,    100, 0, 0, "R4");   // D = 2 by truncation
    run_phase(60,   0, 0, 5*64,  100, 0, 0, "R4");
    run_phase(120,  0, 0, 5*32,  100, 0, 1, "R6");   // change with data
    run_phase(3840, 0, 0, 10,    100, 0, 0, "R3");
    run_phase(240,  0, 0, 4*16,  100, 0, 1, "R6");   // pass-through to D = 16

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R4 watchdog: actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule